// File: doc/BRIEF.md
# Cascadable Serial Bitstream Store

This block is the read-side control of a sequential serial configuration memory. A configuration master supplies a clock, and the block presents one stored bit per clock on a serial data line. The data line is modelled as a value plus an output enable. The stored bits are a small internal array whose contents come from a parameter. Bit `k` of the `INIT_BITS` parameter is the bit presented while the internal address equals `k`, so the stream runs from bit 0 upward.

An internal address counter moves forward on each rising clock edge while the chip is enabled. After the highest address has been presented, the counter saturates. The block then releases the data line and pulls its cascade-enable output low. Several devices can therefore be chained, each one's cascade output driving the next one's active-low enable, so that they share one data line and form a single continuous bitstream.

A reset pin of parameter-selected polarity rewinds the counter. While that pin stays inactive, the counter keeps its position, so a later read pass resumes where the previous one stopped. A separate synchronous power-up reset also clears the counter. A status flag reports standby whenever the chip enable is high.

Top module: `serial_cfg_store`

## Requirements
- R1: With power-up reset low, the reset pin inactive and `ce_n` low, each rising `cclk` edge advances the address by one while the address is below terminal count. Terminal count is `DEPTH-1`.
- R2: When the address is at terminal count and the enabled conditions of R1 hold, the next edge marks the device as exhausted. From then on the address no longer changes, `data_oe` is 0 and `ceo_n` is 0 while `ce_n` is low and reset is inactive.
- R3: With the reset pin active and `ce_n` low, the next edge sets the address to 0 and clears the exhausted state. While reset is active, `data_oe` is 0 and `ceo_n` is 1.
- R4: With `ce_n` high and reset inactive, the address and the exhausted state hold. `data_oe` is 0, `ceo_n` is 1 and `standby` is 1.
- R5: With `ce_n` high and reset active, the next edge clears the address to 0. The outputs are as in R4.
- R6: The reset pin `rst_oe` is active high when `RST_ACT_HIGH` is 1 and active low when it is 0. At its inactive level it has no effect.
- R7: While not exhausted, with `ce_n` low and reset inactive, `data_oe` is 1, `data_o` equals `INIT_BITS[address]` and `ceo_n` is 1. In a chain where one device's `ceo_n` drives the next one's `ce_n`, at most one device drives at any time. The shared stream is the first device's bits 0 to `DEPTH-1`, followed at once by the second device's bits.
- R8: Removing the chip enable (`ce_n` high) with reset inactive and then restoring it resumes the stream at the next unread bit, without rewinding.
- R9: The synchronous active-high `por` input clears the address and the exhausted state on the next edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cclk | input | 1 | Configuration clock; rising edge advances the address |
| por | input | 1 | Synchronous active-high power-up reset |
| ce_n | input | 1 | Active-low chip enable |
| rst_oe | input | 1 | Rewind pin; polarity chosen by `RST_ACT_HIGH` |
| data_o | output | 1 | Serial data value (0 when not driven) |
| data_oe | output | 1 | High when the device drives the data line |
| ceo_n | output | 1 | Active-low cascade enable for the next device |
| standby | output | 1 | High while the chip enable is removed |

## Verification
Two devices are chained on one data line, with opposite reset polarities. The bench compares them against a behavioural model on every clock. A continuous read from address 0 through both memories shows that the handoff between devices loses no bit and duplicates none. An enable gap in the middle of the first memory separates resuming from rewinding. Each device is reset on its own, once with the enable low and once with it high, to separate the enable-low and standby reset paths. Holding the second device's reset pin at a high level during streaming shows that its low-active polarity is respected.

// File: rtl/serial_cfg_store_pkg.sv
package serial_cfg_store_pkg;

  // Decode a rewind pin into an active flag for the selected polarity.
  function automatic logic rewind_active(input logic pin, input bit act_high);
    return act_high ? pin : ~pin;
  endfunction

  // Line state presented by the output stage.
  typedef enum logic [1:0] {
    LINE_OFF    = 2'd0,
    LINE_DRIVE  = 2'd1,
    LINE_HANDON = 2'd2
  } line_state_e;

endpackage

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rewind,
  input  logic              ce_n,
  output logic [ADDR_W-1:0] addr,
  output logic              spent
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (por || rewind) begin
      addr  <= '0;
      spent <= 1'b0;
    end else if (!ce_n && !spent) begin
      if (addr == LAST) begin
        spent <= 1'b1;
      end else begin
        addr <= addr + 1'b1;
      end
    end
  end

  a_r1_advance : assert property (@(posedge clk) disable iff (por)
    (!rewind && !ce_n && !spent && addr != LAST) |=> (addr == $past(addr) + 1'b1));

  a_r2_saturate : assert property (@(posedge clk) disable iff (por)
    (!rewind && spent) |=> (spent && $stable(addr)));

  a_r3_rewind : assert property (@(posedge clk) disable iff (por)
    rewind |=> (addr == '0 && !spent));

  a_r4_hold : assert property (@(posedge clk) disable iff (por)
    (!rewind && ce_n) |=> ($stable(addr) && $stable(spent)));

endmodule

// File: rtl/cfg_bit_rom.sv
module cfg_bit_rom #(
  parameter int              DEPTH     = 64,
  parameter int              ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter logic [DEPTH-1:0] INIT_BITS = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              bit_o
);

  logic mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign mem[i] = INIT_BITS[i];
  end

  assign bit_o = mem[addr];

endmodule

// File: rtl/cfg_pin_ctl.sv
module cfg_pin_ctl
  import serial_cfg_store_pkg::*;
(
  input  logic clk,
  input  logic por,
  input  logic ce_n,
  input  logic rewind,
  input  logic spent,
  input  logic bit_i,
  output logic data_o,
  output logic data_oe,
  output logic ceo_n,
  output logic standby
);

  line_state_e line_st;

  always_comb begin
    if (ce_n || rewind) line_st = LINE_OFF;
    else if (spent)     line_st = LINE_HANDON;
    else                line_st = LINE_DRIVE;
  end

  assign data_oe = (line_st == LINE_DRIVE);
  assign data_o  = data_oe & bit_i;
  assign ceo_n   = (line_st != LINE_HANDON);
  assign standby = ce_n;

  a_r7_one_role : assert property (@(posedge clk) disable iff (por)
    !(data_oe && !ceo_n));

  a_r4_quiet : assert property (@(posedge clk) disable iff (por)
    ce_n |-> (!data_oe && ceo_n && standby));

  a_r3_quiet : assert property (@(posedge clk) disable iff (por)
    rewind |-> (!data_oe && ceo_n));

endmodule

// File: rtl/serial_cfg_store.sv
module serial_cfg_store
  import serial_cfg_store_pkg::*;
#(
  parameter int              DEPTH        = 64,
  parameter bit              RST_ACT_HIGH = 1'b1,
  parameter logic [DEPTH-1:0] INIT_BITS   = '0
) (
  input  logic cclk,
  input  logic por,
  input  logic ce_n,
  input  logic rst_oe,
  output logic data_o,
  output logic data_oe,
  output logic ceo_n,
  output logic standby
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              rewind;
  logic [ADDR_W-1:0] addr;
  logic              spent;
  logic              cur_bit;

  // R6: polarity of the rewind pin
  assign rewind = rewind_active(rst_oe, RST_ACT_HIGH);

  cfg_addr_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctr (
    .clk    (cclk),
    .por    (por),
    .rewind (rewind),
    .ce_n   (ce_n),
    .addr   (addr),
    .spent  (spent)
  );

  cfg_bit_rom #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .INIT_BITS(INIT_BITS)) u_rom (
    .addr  (addr),
    .bit_o (cur_bit)
  );

  cfg_pin_ctl u_pins (
    .clk     (cclk),
    .por     (por),
    .ce_n    (ce_n),
    .rewind  (rewind),
    .spent   (spent),
    .bit_i   (cur_bit),
    .data_o  (data_o),
    .data_oe (data_oe),
    .ceo_n   (ceo_n),
    .standby (standby)
  );

  a_r9_por_clear : assert property (@(posedge cclk)
    por |=> (addr == '0 && !spent));

endmodule

// File: tb/serial_cfg_store_bench.sv
module serial_cfg_store_bench;

  localparam int PERIOD = 10;
  localparam int D1 = 16;
  localparam int D2 = 12;
  localparam logic [D1-1:0] IMG1 = 16'hA5C3;
  localparam logic [D2-1:0] IMG2 = 12'h6E1;

  logic clk = 1'b0;
  logic por, ce1_n, rst1, rst2_pin;
  logic d1, oe1, ceo1_n, sb1;
  logic d2, oe2, ceo2_n, sb2;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int m_addr1 = 0, m_addr2 = 0;
  bit m_spent1 = 0, m_spent2 = 0;
  bit cap_en = 0;
  bit stream[$];

  always #(PERIOD/2) clk = ~clk;

  serial_cfg_store #(.DEPTH(D1), .RST_ACT_HIGH(1'b1), .INIT_BITS(IMG1)) u_serial_cfg_store (
    .cclk(clk), .por(por), .ce_n(ce1_n), .rst_oe(rst1),
    .data_o(d1), .data_oe(oe1), .ceo_n(ceo1_n), .standby(sb1)
  );

  serial_cfg_store #(.DEPTH(D2), .RST_ACT_HIGH(1'b0), .INIT_BITS(IMG2)) u_serial_cfg_store_b (
    .cclk(clk), .por(por), .ce_n(ceo1_n), .rst_oe(rst2_pin),
    .data_o(d2), .data_oe(oe2), .ceo_n(ceo2_n), .standby(sb2)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected outputs follow from the requirements and the model state.
  task automatic check_all(input string tag);
    bit a1, a2, e_oe1, e_ceo1, e_oe2, e_ceo2, ce2;
    a1 = rst1;
    a2 = !rst2_pin;
    e_oe1  = !ce1_n && !a1 && !m_spent1;
    e_ceo1 = !(!ce1_n && !a1 && m_spent1);
    ce2    = e_ceo1;
    e_oe2  = !ce2 && !a2 && !m_spent2;
    e_ceo2 = !(!ce2 && !a2 && m_spent2);
    check(oe1 == e_oe1,   tag, "dev1 data_oe", oe1, e_oe1);
    check(ceo1_n == e_ceo1, tag, "dev1 ceo_n", ceo1_n, e_ceo1);
    check(sb1 == ce1_n,   tag, "dev1 standby", sb1, ce1_n);
    if (e_oe1) check(d1 == IMG1[m_addr1], tag, "dev1 data", d1, IMG1[m_addr1]);
    check(oe2 == e_oe2,   tag, "dev2 data_oe", oe2, e_oe2);
    check(ceo2_n == e_ceo2, tag, "dev2 ceo_n", ceo2_n, e_ceo2);
    check(sb2 == ce2,     tag, "dev2 standby", sb2, ce2);
    if (e_oe2) check(d2 == IMG2[m_addr2], tag, "dev2 data", d2, IMG2[m_addr2]);
    check((oe1 + oe2) <= 1, "R7", "drivers on shared line", oe1 + oe2, 1);
  endtask

  task automatic capture();
    if (oe1 && !oe2) stream.push_back(d1);
    else if (oe2 && !oe1) stream.push_back(d2);
  endtask

  task automatic model_edge();
    bit a1, a2, ce2;
    a1  = rst1;
    a2  = !rst2_pin;
    ce2 = !(!ce1_n && !a1 && m_spent1);
    if (por || a1) begin m_addr1 = 0; m_spent1 = 0; end
    else if (!ce1_n && !m_spent1) begin
      if (m_addr1 == D1 - 1) m_spent1 = 1; else m_addr1++;
    end
    if (por || a2) begin m_addr2 = 0; m_spent2 = 0; end
    else if (!ce2 && !m_spent2) begin
      if (m_addr2 == D2 - 1) m_spent2 = 1; else m_addr2++;
    end
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all(tag);
    if (cap_en) capture();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    por = 1; ce1_n = 1; rst1 = 0; rst2_pin = 1;
    @(negedge clk);
    repeat (2) cycle("R9");
    ce1_n = 0; #1;
    check_all("R9");
    por = 0; #1;
    cap_en = 1;
    capture();
    repeat (5) cycle("R1");
    ce1_n = 1; #1;
    check_all("R4");
    repeat (3) cycle("R4");
    ce1_n = 0; #1;
    check_all("R8");
    repeat (D1 + D2 + 3) cycle("R2");
    cap_en = 0;
    // R7 R8: both images in order, no gap and no repeat across the pause or handoff
    check(stream.size() == D1 + D2, "R7", "stream length", stream.size(), D1 + D2);
    for (int i = 0; i < D1 + D2 && i < stream.size(); i++) begin
      if (i < D1) check(stream[i] == IMG1[i], "R8", "stream bit dev1", stream[i], IMG1[i]);
      else        check(stream[i] == IMG2[i-D1], "R7", "stream bit dev2", stream[i], IMG2[i-D1]);
    end
    check(ceo2_n == 1'b0, "R2", "dev2 ceo_n after last bit", ceo2_n, 0);
    rst1 = 1; #1;
    check_all("R3");
    repeat (2) cycle("R3");
    rst2_pin = 0; #1;
    check_all("R5");
    repeat (2) cycle("R5");
    rst1 = 0; rst2_pin = 1; #1;
    check_all("R6");
    check(oe1 == 1'b1 && d1 == IMG1[0], "R6", "dev1 restarts at bit 0", d1, IMG1[0]);
    repeat (D1 + 3) cycle("R6");
    check(oe2 == 1'b1 && d2 == IMG2[3], "R5", "dev2 resumed from cleared address", d2, IMG2[3]);
    finish_run();
  end

endmodule